// File: doc/BRIEF.md
# Oversampled Nine-Bit Serial Receiver

This block receives asynchronous serial frames of eleven bit periods: a low start bit, eight data bits with the least significant bit first, a ninth bit, and a high stop bit. The line is retimed by a two-flop synchronizer. A free-running 16-state phase counter advances on an external x16 sample tick. Each bit is decided by a majority vote over three samples taken in the middle of the bit period.

A received byte moves from the input shift register into a holding buffer, and the ninth bit moves into its own register. The block then raises a receive flag. Because of this double buffering, software has almost a full frame time to read the previous byte. An address-filter mode can discard frames whose ninth bit is 0, so a node on a shared line only wakes for address frames. A single sticky error flag reports two faults: an overrun, where a frame arrives while the previous byte is unread, and a framing error, where the stop bit is sampled low.

Top module: `mp_uart_rx`

## Requirements
- R1: While idle, the phase counter is held at 0. A high-to-low change of the synchronized line (two flops after `rxd_i`) starts a frame.
- R2: In every bit period the synchronized line is sampled when the phase counter is 7, 8 and 9, counted on `tick_i`. The bit value is the majority of the three samples, so a glitch that corrupts one sample has no effect.
- R3: If the start bit votes 1, the receiver returns to idle at phase 10. The buffer and both flags stay unchanged.
- R4: Data bits are assembled least significant bit first. `rx_data_o[0]` is the first bit after the start bit. The ninth bit is the bit period that follows the eight data bits.
- R5: At phase 10 of the ninth-bit period, if `ri_o` is 0 and (`sm2_i` is 0 or the ninth bit is 1), the byte loads into `rx_data_o` and the ninth bit loads into `rx_bit9_o`. `ri_o` rises one clock later.
- R6: If `sm2_i` is 1 and the ninth bit is 0, the frame is discarded. `rx_data_o`, `rx_bit9_o`, `ri_o` and `err_o` stay unchanged.
- R7: If a frame would be accepted but `ri_o` is already 1, the new byte is lost and `rx_data_o` keeps the old byte. `err_o` rises one clock after phase 10 of the stop bit.
- R8: If the stop bit votes 0, `err_o` rises one clock after phase 10 of the stop bit. The byte is still loaded when the R5 condition holds.
- R9: After an overrun or framing error, later frames are received normally.
- R10: `ri_o` and `err_o` stay set until their clear strobe (`clr_ri_i`, `clr_err_i`) is high for a clock. If a set and a clear fall in the same clock, the set wins.
- R11: After reset, `rx_data_o` is 0, `rx_bit9_o` is 0, `ri_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample tick, 16 per bit period |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| sm2_i | input | 1 | Address-filter mode: accept only frames whose ninth bit is 1 |
| clr_ri_i | input | 1 | One-clock strobe that clears the receive flag |
| clr_err_i | input | 1 | One-clock strobe that clears the error flag |
| rx_data_o | output | 8 | Receive buffer |
| rx_bit9_o | output | 1 | Ninth bit of the last accepted frame |
| ri_o | output | 1 | Receive flag |
| err_o | output | 1 | Overrun or framing error flag |

## Verification
The tests use the following frames:
- Clean frames with varied bytes tell apart bit order and ninth-bit capture.
- A frame sent while the previous byte is unread separates overrun from a normal load.
- A frame with ninth bit 0 under the filter shows that discard leaves no trace, and a frame with ninth bit 1 under the filter shows that it still loads.
- A low stop bit, a short low pulse that fakes a start, and two-clock glitches placed inside data bits probe the framing check, the start vote and the majority vote.
- A clear strobe held high across a flag-setting frame shows that the set wins.

A behavioural model predicts every output on every clock, so any timing slip of the load or the flags shows up at once.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/mp_rx_line_sync.sv
module mp_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= 1'b1;
        else     sr_q <= rxd_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[STAGES-2:0], rxd_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sr_q[STAGES-1];
  end

  assign line_o = sr_q[STAGES-1];
  assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/mp_rx_bit_timer.sv
module mp_rx_bit_timer #(
  parameter int OSR        = 16,
  parameter int SAMP_FIRST = 7,
  parameter int NBITS      = 11,
  localparam int CNT_W     = $clog2(OSR),
  localparam int IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             sample_o,
  output logic             decide_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(SAMP_FIRST);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(SAMP_FIRST + 2);
  localparam logic [CNT_W-1:0] S_DEC = CNT_W'(SAMP_FIRST + 3);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (done_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      cnt_q <= '0;
      idx_q <= '0;
      if (start_i) busy_q <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q == S_END) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign sample_o = busy_q & tick_i & (cnt_q >= S_LO) & (cnt_q <= S_HI);
  assign decide_o = busy_q & tick_i & (cnt_q == S_DEC);
  assign idx_o    = idx_q;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cnt_q == '0));

  assert_bit_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick_i && cnt_q == S_END && !done_i) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/mp_rx_vote.sv
module mp_rx_vote (
  input  logic clk,
  input  logic rst,
  input  logic sample_i,
  input  logic line_i,
  output logic maj_o
);
  import mp_uart_rx_pkg::*;

  logic [2:0] v_q;

  always_ff @(posedge clk) begin
    if (rst)           v_q <= 3'b111;
    else if (sample_i) v_q <= {v_q[1:0], line_i};
  end

  assign maj_o = maj3(v_q);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SAMP_FIRST  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              sm2_i,
  input  logic              clr_ri_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              ri_o,
  output logic              err_o
);
  localparam int NBITS = DATA_W + 3;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [IDX_W-1:0] NINTH_IDX = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(DATA_W + 2);

  logic             line, fall;
  logic             busy, sample_en, decide_en, maj, frame_done;
  logic [IDX_W-1:0] idx;

  logic [DATA_W-1:0] sh_q, data_q;
  logic              bit9_q, ri_q, err_q, ri_set_q, err_set_q, ovr_q;
  logic              accept, load;

  mp_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd_i(rxd_i), .line_o(line), .fall_o(fall)
  );

  mp_rx_bit_timer #(.OSR(OSR), .SAMP_FIRST(SAMP_FIRST), .NBITS(NBITS)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(fall), .done_i(frame_done),
    .busy_o(busy), .sample_o(sample_en), .decide_o(decide_en), .idx_o(idx)
  );

  mp_rx_vote u_vote (
    .clk(clk), .rst(rst), .sample_i(sample_en), .line_i(line), .maj_o(maj)
  );

  assign frame_done = decide_en & (((idx == '0) & maj) | (idx == STOP_IDX));
  assign accept     = ~sm2_i | maj;
  assign load       = decide_en & (idx == NINTH_IDX) & accept & ~ri_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      data_q    <= '0;
      bit9_q    <= 1'b0;
      ri_set_q  <= 1'b0;
      err_set_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      ri_set_q  <= 1'b0;
      err_set_q <= 1'b0;
      if (decide_en) begin
        if (idx != '0 && idx < NINTH_IDX) sh_q <= {maj, sh_q[DATA_W-1:1]};
        if (idx == NINTH_IDX) begin
          if (load) begin
            data_q   <= sh_q;
            bit9_q   <= maj;
            ri_set_q <= 1'b1;
          end
          if (accept && ri_q) ovr_q <= 1'b1;
        end
        if (idx == STOP_IDX) begin
          err_set_q <= ~maj | ovr_q;
          ovr_q     <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ri_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ri_set_q)       ri_q <= 1'b1;
      else if (clr_ri_i)  ri_q <= 1'b0;
      if (err_set_q)      err_q <= 1'b1;
      else if (clr_err_i) err_q <= 1'b0;
    end
  end

  assign rx_data_o = data_q;
  assign rx_bit9_o = bit9_q;
  assign ri_o      = ri_q;
  assign err_o     = err_q;

  assert_flag_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> ##2 ri_o);

  assert_keep_buffer_R7: assert property (@(posedge clk) disable iff (rst)
    (ri_o && !clr_ri_i) |=> $stable(rx_data_o));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_err_i) |=> err_o);

  assert_ri_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ri_o && !clr_ri_i) |=> ri_o);

  assert_reject_frees_R3: assert property (@(posedge clk) disable iff (rst)
    (decide_en && idx == '0 && maj) |=> !busy);
endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
  logic       clk = 1'b0;
  logic       rst, tick, rxd, sm2, clr_ri, clr_err;
  logic [7:0] rx_data;
  logic       rx_bit9, ri, err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mp_uart_rx u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .rxd_i(rxd), .sm2_i(sm2),
    .clr_ri_i(clr_ri), .clr_err_i(clr_err),
    .rx_data_o(rx_data), .rx_bit9_o(rx_bit9), .ri_o(ri), .err_o(err)
  );

  // Sample tick every 4 clocks, so one bit period is 64 clocks.
  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // Behavioural reference model, stepped on every rising edge.
  int  m_hist[$];
  bit  m_busy, m_ri, m_err, m_rip, m_errp, m_ovr, m_b9;
  int  m_cnt, m_idx, m_ones;
  int  m_sh, m_data;

  always @(posedge clk) begin
    int  line, prev, maj;
    bit  nrip, nerrp, done;
    if (rst) begin
      m_hist = '{1, 1, 1};
      m_busy = 0; m_cnt = 0; m_idx = 0; m_ones = 3;
      m_ri = 0; m_err = 0; m_rip = 0; m_errp = 0; m_ovr = 0;
      m_sh = 0; m_data = 0; m_b9 = 0;
    end else begin
      line = m_hist[1];
      prev = m_hist[0];
      nrip = 0; nerrp = 0; done = 0;
      maj  = (m_ones >= 2);
      if (m_busy && tick) begin
        if (m_cnt == 10) begin
          if (m_idx == 0 && maj == 1) done = 1;
          else if (m_idx >= 1 && m_idx <= 8) m_sh = (m_sh >> 1) | (maj << 7);
          else if (m_idx == 9) begin
            if (!sm2 || maj == 1) begin
              if (!m_ri) begin m_data = m_sh; m_b9 = maj[0]; nrip = 1; end
              else m_ovr = 1;
            end
          end else if (m_idx == 10) begin
            nerrp = (maj == 0) || m_ovr;
            m_ovr = 0;
            done = 1;
          end
        end
        if (m_cnt == 7) m_ones = line;
        else if (m_cnt == 8 || m_cnt == 9) m_ones += line;
        if (done) begin m_busy = 0; m_cnt = 0; m_idx = 0; end
        else if (m_cnt == 15) begin m_cnt = 0; m_idx++; end
        else m_cnt++;
      end else if (!m_busy && prev == 1 && line == 0) begin
        m_busy = 1; m_cnt = 0; m_idx = 0;
      end
      if (m_rip) m_ri = 1; else if (clr_ri) m_ri = 0;
      if (m_errp) m_err = 1; else if (clr_err) m_err = 0;
      m_rip = nrip; m_errp = nerrp;
      m_hist.delete(0);
      m_hist.push_back(rxd);
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (ri !== m_ri || rx_data !== m_data[7:0] || rx_bit9 !== m_b9) begin
        errors++;
        $display("FAIL R5 model: ri=%b data=%h b9=%b expected ri=%b data=%h b9=%b",
                 ri, rx_data, rx_bit9, m_ri, m_data[7:0], m_b9);
      end
      checks++;
      if (err !== m_err) begin
        errors++;
        $display("FAIL R7 model: err=%b expected %b", err, m_err);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop_v, input bit glitch);
    logic [10:0] bits;
    bits = {stop_v, b9, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      rxd = bits[b];
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        if (glitch && b >= 1 && b <= 8) begin
          if (c == 34) rxd = ~bits[b];
          if (c == 36) rxd = bits[b];
        end
      end
    end
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic clear_flags;
    @(negedge clk); clr_ri = 1; clr_err = 1;
    @(negedge clk); clr_ri = 0; clr_err = 0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1; rxd = 1; sm2 = 0; clr_ri = 0; clr_err = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 data", rx_data, 0); chk("R11 b9", rx_bit9, 0);
    chk("R11 ri", ri, 0);        chk("R11 err", err, 0);

    send(8'hA5, 1'b0, 1'b1, 0);
    chk("R4 data", rx_data, 8'hA5); chk("R5 ri", ri, 1); chk("R4 b9", rx_bit9, 0);

    send(8'h3C, 1'b1, 1'b1, 0);  // RI still set: overrun
    chk("R7 keep", rx_data, 8'hA5); chk("R7 err", err, 1);
    clear_flags();

    sm2 = 1;
    send(8'h77, 1'b0, 1'b1, 0);  // filtered out
    chk("R6 ri", ri, 0); chk("R6 data", rx_data, 8'hA5); chk("R6 err", err, 0);

    send(8'h81, 1'b1, 1'b1, 0);  // address frame accepted
    chk("R5 data", rx_data, 8'h81); chk("R5 b9", rx_bit9, 1); chk("R5 ri", ri, 1);
    repeat (100) @(negedge clk);
    chk("R10 sticky", ri, 1);
    sm2 = 0;
    clear_flags();

    send(8'h0F, 1'b0, 1'b0, 0);  // low stop bit
    chk("R8 err", err, 1); chk("R8 data", rx_data, 8'h0F);
    clear_flags();

    send(8'hC3, 1'b1, 1'b1, 0);
    chk("R9 data", rx_data, 8'hC3); chk("R9 ri", ri, 1); chk("R9 err", err, 0);
    clear_flags();

    rxd = 0; repeat (12) @(negedge clk); rxd = 1;  // false start
    repeat (200) @(negedge clk);
    chk("R3 ri", ri, 0); chk("R3 data", rx_data, 8'hC3); chk("R3 err", err, 0);

    send(8'h5A, 1'b0, 1'b1, 0);
    chk("R1 data", rx_data, 8'h5A);
    clear_flags();

    send(8'h55, 1'b1, 1'b1, 1);  // single-sample glitches
    chk("R2 data", rx_data, 8'h55); chk("R2 b9", rx_bit9, 1);
    clear_flags();

    begin : set_wins
      bit seen;
      seen = 0;
      clr_ri = 1;
      fork
        send(8'h99, 1'b0, 1'b1, 0);
        repeat (700) begin @(negedge clk); if (ri) seen = 1; end
      join
      clr_ri = 0;
      chk("R10 set wins", seen, 1);
      chk("R10 data", rx_data, 8'h99);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule